// File: doc/BRIEF.md
# 64b/66b Receive Block Decoder

This block sits on the receive side of a 64b/66b link, behind block alignment and descrambling. Each cycle it may accept one 66-bit block: a 2-bit sync header plus a 64-bit body. It returns eight octets with a per-octet control flag. Data blocks pass straight through. Control blocks are looked up by their type byte. Their packed 7-bit control codes are widened back to 8-bit control characters, and start and terminate characters are placed in the lanes that the type implies.

A small tracker follows packet boundaries: idle, or inside a packet. Blocks that are malformed, or that arrive in the wrong place in the packet sequence, replace the whole output word with error characters. The packet in progress then carries an error marker to the receiver and is discarded there. A single bad 7-bit code only turns its own lane into an error character. Results appear one clock after the block is accepted.

Top module: `blk66_decoder`

## Requirements
- R1: A block with header 01 received inside a packet outputs lane j = body[8j+7:8j] for every lane, and all eight control flags are 0.
- R2: A block with header 00 or 11 outputs 0xFE in all eight lanes with all flags 1, and leaves the packet state unchanged.
- R3: A block with header 10 whose type byte body[7:0] is not one of 0x1e, 0x33, 0x78, 0x87, 0x99, 0xaa, 0xb4, 0xcc, 0xd2, 0xe1, 0xff outputs the all-error word (0xFE, flags 1) and leaves the packet state unchanged.
- R4: The start character is 0xFB. Type 0x78 puts start in lane 0 and data body[8j+7:8j] in lanes 1 to 7. Type 0x33 puts control codes in lanes 0 to 3, start in lane 4 and data body[8j+7:8j] in lanes 5 to 7.
- R5: Types 0x87, 0x99, 0xaa, 0xb4, 0xcc, 0xd2, 0xe1, 0xff put the terminate character 0xFD in lane k = 0 to 7 in that order. Lanes j below k carry data body[8j+15:8j+8] with flag 0. Lanes above k carry control codes.
- R6: The 7-bit code for lane j sits at body[7j+14:7j+8]. Codes map 0x00→0x07, 0x1e→0xFE, 0x2d→0x1C, 0x33→0x3C, 0x4b→0x7C, 0x55→0x9C, 0x66→0xBC, 0x78→0xDC, and any other code gives 0xFE in that lane only. Every code-decoded lane has flag 1. Type 0x1e decodes all eight lanes as codes.
- R7: The state is idle after reset. A start block moves it into a packet. A data block while idle, or a start block while inside a packet, gives the all-error word, and after such a start the state is inside a packet.
- R8: A terminate block while inside a packet returns the state to idle. A terminate block while idle, or a type 0x1e block while inside a packet, gives the all-error word and leaves the state idle.
- R9: Each accepted block produces out_valid one clock later. A cycle with in_valid low produces out_valid low one clock later and does not change the packet state.
- R10: While rst is high at a clock edge, out_valid, out_octets and out_is_ctl are all cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A block is presented this cycle |
| in_hdr | input | 2 | Sync header of the block |
| in_body | input | 64 | Descrambled block body, type byte in bits 7:0 for control blocks |
| out_valid | output | 1 | Decoded word valid |
| out_octets | output | 64 | Eight decoded octets, lane j in bits 8j+7:8j |
| out_is_ctl | output | 8 | Per-lane control flag |

## Verification
The bench goes after every terminate position, because an off-by-one in the data shift or code offset would move octets into the wrong lane for only some positions. It tests the lane-4 start, where a decoder that handled only lane-0 starts would output data or codes where start should be. It runs sequence faults: data while idle, start inside a packet, terminate while idle and an all-control block inside a packet. A tracker that ignored these would let a damaged packet through without an error. Bad headers, unknown types and stray 7-bit codes are mixed into random traffic with idle gaps. This catches a decoder that errors the whole word instead of one lane, or that changes state on a gap.

// File: rtl/blk66_pkg.sv
package blk66_pkg;
  localparam int LANES   = 8;
  localparam int OCT_W   = 8;
  localparam int CODE_W  = 7;
  localparam int TYPE_W  = 8;
  localparam int BODY_W  = LANES * OCT_W;
  localparam int LANE_IW = $clog2(LANES);
  localparam int START_HI_LANE = LANES / 2;

  localparam logic [OCT_W-1:0] CH_ERR   = 8'hFE;
  localparam logic [OCT_W-1:0] CH_START = 8'hFB;
  localparam logic [OCT_W-1:0] CH_TERM  = 8'hFD;

  typedef enum logic [2:0] {
    BK_DATA, BK_CTRL, BK_START, BK_TERM, BK_BAD
  } blk_kind_t;

  // {legal, character}
  function automatic logic [OCT_W:0] code_to_char(input logic [CODE_W-1:0] c);
    case (c)
      7'h00:   return {1'b1, 8'h07};
      7'h1e:   return {1'b1, 8'hFE};
      7'h2d:   return {1'b1, 8'h1C};
      7'h33:   return {1'b1, 8'h3C};
      7'h4b:   return {1'b1, 8'h7C};
      7'h55:   return {1'b1, 8'h9C};
      7'h66:   return {1'b1, 8'hBC};
      7'h78:   return {1'b1, 8'hDC};
      default: return {1'b0, CH_ERR};
    endcase
  endfunction

  // {is_terminate, lane}
  function automatic logic [LANE_IW:0] term_lane(input logic [TYPE_W-1:0] t);
    case (t)
      8'h87:   return {1'b1, 3'd0};
      8'h99:   return {1'b1, 3'd1};
      8'haa:   return {1'b1, 3'd2};
      8'hb4:   return {1'b1, 3'd3};
      8'hcc:   return {1'b1, 3'd4};
      8'hd2:   return {1'b1, 3'd5};
      8'he1:   return {1'b1, 3'd6};
      8'hff:   return {1'b1, 3'd7};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/blk66_classify.sv
module blk66_classify
  import blk66_pkg::*;
(
  input  logic [1:0]         hdr,
  input  logic [TYPE_W-1:0]  type_b,
  output blk_kind_t          kind,
  output logic [LANE_IW-1:0] tlane,
  output logic               start_hi
);
  logic [LANE_IW:0] tl;

  always_comb begin
    tl       = term_lane(type_b);
    tlane    = tl[LANE_IW-1:0];
    start_hi = 1'b0;
    kind     = BK_BAD;
    if (hdr == 2'b01) begin
      kind = BK_DATA;
    end else if (hdr == 2'b10) begin
      if (type_b == 8'h1e) begin
        kind = BK_CTRL;
      end else if (type_b == 8'h78) begin
        kind = BK_START;
      end else if (type_b == 8'h33) begin
        kind     = BK_START;
        start_hi = 1'b1;
      end else if (tl[LANE_IW]) begin
        kind = BK_TERM;
      end
    end
  end
endmodule

// File: rtl/blk66_lanes.sv
module blk66_lanes
  import blk66_pkg::*;
(
  input  logic [BODY_W-1:0]  body,
  input  blk_kind_t          kind,
  input  logic [LANE_IW-1:0] tlane,
  input  logic               start_hi,
  output logic [BODY_W-1:0]  octets,
  output logic [LANES-1:0]   is_ctl
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int CODE_LO = TYPE_W + CODE_W * j;
    logic [CODE_W-1:0] code;
    logic [OCT_W-1:0]  raw, shf, oct;
    logic [OCT_W:0]    cm;
    logic              ctl;

    assign code = body[CODE_LO +: CODE_W];
    assign raw  = body[OCT_W*j +: OCT_W];
    if (j < LANES - 1) begin : g_shf
      assign shf = body[TYPE_W + OCT_W*j +: OCT_W];
    end else begin : g_noshf
      assign shf = '0;
    end

    always_comb begin
      cm  = code_to_char(code);
      oct = CH_ERR;
      ctl = 1'b1;
      case (kind)
        BK_DATA: begin
          oct = raw;
          ctl = 1'b0;
        end
        BK_CTRL: oct = cm[OCT_W-1:0];
        BK_START: begin
          if (start_hi && j < START_HI_LANE) begin
            oct = cm[OCT_W-1:0];
          end else if ((start_hi && j == START_HI_LANE) || (!start_hi && j == 0)) begin
            oct = CH_START;
          end else begin
            oct = raw;
            ctl = 1'b0;
          end
        end
        BK_TERM: begin
          if (j < int'(tlane)) begin
            oct = shf;
            ctl = 1'b0;
          end else if (j == int'(tlane)) begin
            oct = CH_TERM;
          end else begin
            oct = cm[OCT_W-1:0];
          end
        end
        default: oct = CH_ERR;
      endcase
    end

    assign octets[OCT_W*j +: OCT_W] = oct;
    assign is_ctl[j]                = ctl;
  end
endmodule

// File: rtl/blk66_track.sv
module blk66_track
  import blk66_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  input  blk_kind_t kind,
  output logic      err_word
);
  typedef enum logic {ST_IDLE, ST_PKT} trk_t;
  trk_t st, st_nxt;

  always_comb begin
    st_nxt   = st;
    err_word = 1'b0;
    case (kind)
      BK_DATA:  err_word = (st == ST_IDLE);
      BK_START: begin
        err_word = (st == ST_PKT);
        st_nxt   = ST_PKT;
      end
      BK_TERM: begin
        err_word = (st == ST_IDLE);
        st_nxt   = ST_IDLE;
      end
      BK_CTRL: begin
        err_word = (st == ST_PKT);
        st_nxt   = ST_IDLE;
      end
      default: err_word = 1'b1;
    endcase
    if (!in_valid) st_nxt = st;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/blk66_decoder.sv
module blk66_decoder
  import blk66_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_hdr,
  input  logic [BODY_W-1:0] in_body,
  output logic              out_valid,
  output logic [BODY_W-1:0] out_octets,
  output logic [LANES-1:0]  out_is_ctl
);
  blk_kind_t          kind;
  logic [LANE_IW-1:0] tlane;
  logic               start_hi;
  logic [BODY_W-1:0]  lane_oct;
  logic [LANES-1:0]   lane_ctl;
  logic               err_word;

  blk66_classify u_cls (
    .hdr      (in_hdr),
    .type_b   (in_body[TYPE_W-1:0]),
    .kind     (kind),
    .tlane    (tlane),
    .start_hi (start_hi)
  );

  blk66_lanes u_lanes (
    .body     (in_body),
    .kind     (kind),
    .tlane    (tlane),
    .start_hi (start_hi),
    .octets   (lane_oct),
    .is_ctl   (lane_ctl)
  );

  blk66_track u_trk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .kind     (kind),
    .err_word (err_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_octets <= '0;
      out_is_ctl <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_octets <= err_word ? {LANES{CH_ERR}} : lane_oct;
        out_is_ctl <= err_word ? {LANES{1'b1}} : lane_ctl;
      end
    end
  end
endmodule

// File: rtl/blk66_decoder_chk.sv
module blk66_decoder_chk
  import blk66_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        in_hdr,
  input logic [BODY_W-1:0] in_body,
  input logic              out_valid,
  input logic [BODY_W-1:0] out_octets,
  input logic [LANES-1:0]  out_is_ctl
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  gap_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  bad_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_hdr == 2'b00 || in_hdr == 2'b11)) |=>
      (out_octets == {LANES{CH_ERR}} && out_is_ctl == {LANES{1'b1}}));

  // R1
  data_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hdr == 2'b01) |=>
      (out_is_ctl == '0 || out_is_ctl == {LANES{1'b1}}));

  // R4
  start_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hdr == 2'b10 && in_body[7:0] == 8'h78) |=>
      (out_is_ctl[0] && (out_octets[7:0] == CH_START || out_octets[7:0] == CH_ERR)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_octets == '0 && out_is_ctl == '0));
endmodule

bind blk66_decoder blk66_decoder_chk u_chk (.*);

// File: tb/blk66_decoder_test.sv
module blk66_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_hdr = 2'b00;
  logic [63:0] in_body = '0;
  logic        out_valid;
  logic [63:0] out_octets;
  logic [7:0]  out_is_ctl;

  always #5 clk = ~clk;

  blk66_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr), .in_body(in_body),
    .out_valid(out_valid), .out_octets(out_octets), .out_is_ctl(out_is_ctl)
  );

  localparam logic [7:0] TT [8] = '{8'h87, 8'h99, 8'haa, 8'hb4, 8'hcc, 8'hd2, 8'he1, 8'hff};
  localparam logic [6:0] GOOD [8] = '{7'h00, 7'h1e, 7'h2d, 7'h33, 7'h4b, 7'h55, 7'h66, 7'h78};

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          ref_in_pkt = 1'b0;
  logic        exp_v = 1'b0;
  logic [63:0] exp_oct = '0;
  logic [7:0]  exp_ctl = '0;
  string       exp_tag = "R10";

  function automatic logic [7:0] ref_code(input logic [6:0] c);
    case (c)
      7'h00: return 8'h07;
      7'h2d: return 8'h1C;
      7'h33: return 8'h3C;
      7'h4b: return 8'h7C;
      7'h55: return 8'h9C;
      7'h66: return 8'hBC;
      7'h78: return 8'hDC;
      default: return 8'hFE;
    endcase
  endfunction

  task automatic set_err(input string tag);
    exp_oct = {8{8'hFE}};
    exp_ctl = 8'hFF;
    exp_tag = tag;
  endtask

  task automatic ref_block(input logic v, input logic [1:0] h, input logic [63:0] b);
    int tk;
    logic [7:0] t;
    exp_v   = v;
    exp_tag = "R9";
    if (!v) return;
    t  = b[7:0];
    tk = -1;
    for (int k = 0; k < 8; k++) if (t == TT[k]) tk = k;
    if (h == 2'b01) begin
      if (!ref_in_pkt) set_err("R7");
      else begin exp_oct = b; exp_ctl = 8'h00; exp_tag = "R1"; end
    end else if (h != 2'b10) begin
      set_err("R2");
    end else if (t == 8'h1e) begin
      if (ref_in_pkt) begin set_err("R8"); ref_in_pkt = 1'b0; end
      else begin
        for (int j = 0; j < 8; j++) exp_oct[8*j +: 8] = ref_code(b[8+7*j +: 7]);
        exp_ctl = 8'hFF; exp_tag = "R6";
      end
    end else if (t == 8'h78 || t == 8'h33) begin
      if (ref_in_pkt) set_err("R7");
      else begin
        for (int j = 0; j < 8; j++) begin
          if (t == 8'h78) begin
            exp_oct[8*j +: 8] = (j == 0) ? 8'hFB : b[8*j +: 8];
            exp_ctl[j] = (j == 0);
          end else if (j < 4) begin
            exp_oct[8*j +: 8] = ref_code(b[8+7*j +: 7]); exp_ctl[j] = 1'b1;
          end else if (j == 4) begin
            exp_oct[8*j +: 8] = 8'hFB; exp_ctl[j] = 1'b1;
          end else begin
            exp_oct[8*j +: 8] = b[8*j +: 8]; exp_ctl[j] = 1'b0;
          end
        end
        exp_tag = "R4";
      end
      ref_in_pkt = 1'b1;
    end else if (tk >= 0) begin
      if (!ref_in_pkt) set_err("R8");
      else begin
        for (int j = 0; j < 8; j++) begin
          if (j < tk) begin exp_oct[8*j +: 8] = b[8+8*j +: 8]; exp_ctl[j] = 1'b0; end
          else if (j == tk) begin exp_oct[8*j +: 8] = 8'hFD; exp_ctl[j] = 1'b1; end
          else begin exp_oct[8*j +: 8] = ref_code(b[8+7*j +: 7]); exp_ctl[j] = 1'b1; end
        end
        exp_tag = "R5";
      end
      ref_in_pkt = 1'b0;
    end else begin
      set_err("R3");
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (out_valid !== exp_v) begin
      n_bad++;
      $display("FAIL %s out_valid: actual=%b expected=%b", (exp_tag == "R10") ? "R10" : "R9",
               out_valid, exp_v);
    end else if ((exp_v || exp_tag == "R10") &&
                 (out_octets !== exp_oct || out_is_ctl !== exp_ctl)) begin
      n_bad++;
      $display("FAIL %s word: actual=%h/%h expected=%h/%h", exp_tag,
               out_octets, out_is_ctl, exp_oct, exp_ctl);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] h, input logic [63:0] b);
    @(negedge clk);
    compare();
    rst = 1'b0;
    ref_block(v, h, b);
    in_valid = v; in_hdr = h; in_body = b;
  endtask

  // R10: reset clears the outputs and returns the tracker to idle
  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rst = 1'b1; in_valid = 1'b0;
      exp_v = 1'b0; exp_oct = '0; exp_ctl = '0; exp_tag = "R10";
      ref_in_pkt = 1'b0;
    end
  endtask

  function automatic logic [63:0] ctl_body(input logic [6:0] c);
    logic [63:0] b = '0;
    b[7:0] = 8'h1e;
    for (int j = 0; j < 8; j++) b[8+7*j +: 7] = c;
    return b;
  endfunction

  function automatic logic [63:0] start_hi_body(input logic [6:0] c, input logic [23:0] d);
    logic [63:0] b = '0;
    b[7:0] = 8'h33;
    for (int j = 0; j < 4; j++) b[8+7*j +: 7] = c;
    b[63:40] = d;
    return b;
  endfunction

  function automatic logic [63:0] term_body(input int k, input logic [63:0] d, input logic [6:0] c);
    logic [63:0] b = '0;
    b[7:0] = TT[k];
    for (int j = 0; j < 8; j++) begin
      if (j < k) b[8+8*j +: 8] = d[8*j +: 8];
      else if (j > k) b[8+7*j +: 7] = c;
    end
    return b;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0066));
    do_reset(3);
    // R6: all-control blocks with each legal code, then a stray code
    for (int i = 0; i < 8; i++) step(1'b1, 2'b10, ctl_body(GOOD[i]));
    step(1'b1, 2'b10, ctl_body(7'h01));
    step(1'b1, 2'b10, ctl_body(7'h7f));
    // R4 lane-0 start, R1 data, R5 every terminate position
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 2'b10, {56'h0123_4567_89AB_CD, 8'h78});
      step(1'b1, 2'b01, 64'hDEAD_BEEF_0BAD_F00D + 64'(k));
      step(1'b1, 2'b10, term_body(k, 64'h8877_6655_4433_2211, GOOD[k]));
    end
    // R4 lane-4 start with codes in lanes 0..3, then terminate with a bad code
    step(1'b1, 2'b10, start_hi_body(7'h00, 24'hA1B2C3));
    step(1'b1, 2'b01, 64'h1111_2222_3333_4444);
    step(1'b1, 2'b10, term_body(2, 64'h00EE, 7'h05));
    step(1'b1, 2'b10, start_hi_body(7'h11, 24'h445566));
    step(1'b1, 2'b10, term_body(0, '0, 7'h00));
    // R9: gaps do not disturb the state
    step(1'b1, 2'b10, {56'hCAFE, 8'h78});
    step(1'b0, 2'b01, 64'h1);
    step(1'b0, 2'b00, 64'h2);
    step(1'b1, 2'b01, 64'h5555_AAAA_5555_AAAA);
    // R2 bad headers inside a packet keep the packet going
    step(1'b1, 2'b00, 64'h1234);
    step(1'b1, 2'b11, 64'h5678);
    step(1'b1, 2'b01, 64'h9ABC);
    // R3 unknown types
    step(1'b1, 2'b10, {56'h0, 8'h2d});
    step(1'b1, 2'b10, {56'h0, 8'h00});
    step(1'b1, 2'b10, term_body(7, 64'h7766_5544_3322_1100, 7'h00));
    // R7: data while idle, start inside a packet
    step(1'b1, 2'b01, 64'hFFFF_0000_FFFF_0000);
    step(1'b1, 2'b10, {56'h1, 8'h78});
    step(1'b1, 2'b10, {56'h2, 8'h78});
    step(1'b1, 2'b01, 64'h77);
    // R8: all-control block inside a packet, then terminate while idle
    step(1'b1, 2'b10, ctl_body(7'h00));
    step(1'b1, 2'b10, term_body(3, 64'h1, 7'h00));
    step(1'b1, 2'b01, 64'h42);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 11);
      logic [6:0] c = ($urandom_range(0, 5) == 0) ? 7'($urandom) : GOOD[$urandom_range(0, 7)];
      case (sel)
        0, 1, 2: step(1'b1, 2'b01, rnd64());
        3:       step(1'b1, 2'b10, ctl_body(c));
        4:       step(1'b1, 2'b10, {rnd64() >> 8, 8'h78});
        5:       step(1'b1, 2'b10, start_hi_body(c, 24'($urandom)));
        6, 7:    step(1'b1, 2'b10, term_body($urandom_range(0, 7), rnd64(), c));
        8:       step(1'b1, ($urandom_range(0, 1) != 0) ? 2'b00 : 2'b11, rnd64());
        9:       step(1'b1, 2'b10, rnd64());
        default: step(1'b0, 2'($urandom), rnd64());
      endcase
    end
    // R10: reset in the middle of a packet, then data must be an error (idle again)
    step(1'b1, 2'b10, {56'hBEEF, 8'h78});
    do_reset(2);
    step(1'b1, 2'b01, 64'h0F0F);
    step(1'b0, 2'b00, '0);
    step(1'b0, 2'b00, '0);
    @(negedge clk);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule